// File: doc/BRIEF.md
# Page Write Buffer with Timed Commit

This block sits behind a two-wire serial slave and gathers the data bytes of one write transaction into a staging buffer that is exactly one page wide. The page is sixteen bytes. A transaction opens when the protocol layer loads a byte address. Each accepted data byte lands at the current offset inside the page. The offset advances in its low four bits only, so it never leaves the page.

When the stop strobe arrives, the bytes collected in the buffer are committed to a byte array of 256 or 512 entries as one page-wide operation. A busy flag covers the whole internal write time, which is a parameter counted in clock cycles. While busy is high, the block refuses all traffic. The accept flag that the block returns for every data strobe drives the acknowledge bit.

A protection input guards the upper half of the array. It is sampled once, on the first data byte of a transaction. A registered read port gives the protocol layer access to the array contents.

Top module: `page_commit_buf`

## Requirements
- R1: After reset every array byte reads 0xFF and busy is low.
- R2: An accepted byte is stored at the current page/offset position. The offset is the low 4 address bits and increments modulo 16 after each accepted byte. The upper address bits, which form the page number, never change during a transaction.
- R3: When more than 16 bytes arrive before stop, the offset wraps and later bytes overwrite earlier ones in the same page. Only the last value sent to each offset is committed.
- R4: A commit writes only the offsets that received a byte. Every other byte of the page, and every other page, keeps its value.
- R5: A stop after at least one accepted byte raises busy on the next clock edge. Busy stays high for exactly WR_CYCLES cycles. The array is updated on the edge where busy falls. While busy is high, reads return the old contents and data strobes are answered with ack_ok = 0 and have no effect.
- R6: If wp_in is 1 when the first data byte of a transaction arrives and the address MSB is 1 (upper half of the array), that byte and every later byte of the transaction get ack_ok = 0. The stop that follows starts no commit.
- R7: wp_in = 0 never affects a write. wp_in = 1 has no effect on lower-half targets. A change of wp_in after the first data byte has no effect.
- R8: A stop that arrives before any data byte starts no commit and leaves busy low.
- R9: Loading a new address clears the byte-valid mask, so bytes collected before the reload are not committed.
- R10: rd_data shows the array byte at rd_addr one clock after rd_addr is applied.
- R11: Every data strobe produces ack_valid = 1 on the next cycle, with ack_ok = 1 only if the byte was accepted. A strobe outside an open transaction (before any address load, or after stop) gets ack_ok = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_load | input | 1 | Opens a transaction at addr_val |
| addr_val | input | AW | Start byte address (AW = log2 of MEM_BYTES) |
| data_stb | input | 1 | One data byte is present on data_in |
| data_in | input | 8 | Data byte |
| stop_stb | input | 1 | End of transaction; starts a commit if any bytes were accepted |
| wp_in | input | 1 | Upper-half write protection |
| busy | output | 1 | Internal write cycle in progress |
| ack_valid | output | 1 | Accept result is valid (one cycle after data_stb) |
| ack_ok | output | 1 | 1 = byte accepted, 0 = refused |
| rd_addr | input | AW | Read address |
| rd_data | output | 8 | Registered read data |

## Verification
The two hardest situations to reach from the ports are the overwrite-by-wrap case and the window inside the busy period. The wrap case needs eighteen bytes sent without a stop. The stimulus then checks that the first two offsets hold the late values and that the rest of the page holds the early ones. To reach the busy window, a data strobe and an array read are issued between the stop and the fall of busy. This shows that the strobe is refused and that the array still holds its old contents. The reads that follow show that the refused byte never reached the next offset. Protection is exercised by changing wp_in both before and after the first byte, with targets in both halves of the array.

// File: rtl/pcb_pkg.sv
package pcb_pkg;

    typedef logic [7:0] byte_t;

    typedef enum logic [1:0] {
        TXN_IDLE    = 2'd0,
        TXN_OPEN    = 2'd1,
        TXN_BLOCKED = 2'd2
    } txn_state_e;

    typedef struct packed {
        logic valid;
        logic ok;
    } ack_t;

    function automatic logic protect_hit(input logic wp, input logic upper_bit);
        return wp & upper_bit;
    endfunction

endpackage

// File: rtl/pcb_page_buffer.sv
module pcb_page_buffer
    import pcb_pkg::*;
#(
    parameter int AW         = 8,
    parameter int PAGE_BYTES = 16,
    localparam int OW        = $clog2(PAGE_BYTES),
    localparam int PW        = AW - OW
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        hold,
    input  logic                        done,
    input  logic                        addr_load,
    input  logic [AW-1:0]               addr_val,
    input  logic                        data_stb,
    input  byte_t                       data_in,
    input  logic                        stop_stb,
    input  logic                        wp_in,
    output logic [PW-1:0]               page,
    output logic [PAGE_BYTES-1:0]       mask,
    output logic [PAGE_BYTES-1:0][7:0]  lanes,
    output logic                        commit_req,
    output ack_t                        ack
);

    txn_state_e    state;
    logic [OW-1:0] off;
    logic          first;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= TXN_IDLE;
            off   <= '0;
            page  <= '0;
            mask  <= '0;
            lanes <= '0;
            first <= 1'b0;
            ack   <= '0;
        end else begin
            ack.valid <= data_stb;
            ack.ok    <= 1'b0;
            if (done) mask <= '0;
            if (!hold) begin
                if (addr_load) begin
                    page  <= addr_val[AW-1:OW];
                    off   <= addr_val[OW-1:0];
                    mask  <= '0;
                    state <= TXN_OPEN;
                    first <= 1'b1;
                end else if (stop_stb) begin
                    state <= TXN_IDLE;
                end else if (data_stb && state == TXN_OPEN) begin
                    first <= 1'b0;
                    if (first && protect_hit(wp_in, page[PW-1])) begin
                        state <= TXN_BLOCKED;
                    end else begin
                        lanes[off] <= data_in;
                        mask[off]  <= 1'b1;
                        off        <= off + 1'b1;
                        ack.ok     <= 1'b1;
                    end
                end
            end
        end
    end

    assign commit_req = stop_stb && !hold && !addr_load && state == TXN_OPEN && (|mask);

    // R2: accepted byte advances offset inside the same page
    assert_offset_in_page_R2: assert property (@(posedge clk) disable iff (rst)
        ack.valid && ack.ok |-> (off == OW'($past(off) + 1'b1)) && $stable(page));

    // R6: a blocked transaction accepts nothing
    assert_blocked_refuses_R6: assert property (@(posedge clk) disable iff (rst)
        ack.valid && $past(state) == TXN_BLOCKED |-> !ack.ok);

    // R5: strobes during the write cycle are refused
    assert_busy_refuses_R5: assert property (@(posedge clk) disable iff (rst)
        ack.valid && $past(hold) |-> !ack.ok);

endmodule

// File: rtl/pcb_commit_timer.sv
module pcb_commit_timer #(
    parameter int CYCLES = 40,
    localparam int CW    = $clog2(CYCLES + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy,
    output logic done
);

    logic [CW-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy   <= 1'b0;
            remain <= '0;
        end else if (!busy && start) begin
            busy   <= 1'b1;
            remain <= CW'(CYCLES - 1);
        end else if (busy) begin
            if (remain == '0) busy <= 1'b0;
            else              remain <= remain - 1'b1;
        end
    end

    assign done = busy && (remain == '0);

    // checker: length of each busy run
    logic [CW:0] run_len;
    always_ff @(posedge clk) begin
        if (rst)       run_len <= '0;
        else if (busy) run_len <= run_len + 1'b1;
        else           run_len <= '0;
    end

    // R5: busy lasts exactly CYCLES cycles
    assert_busy_length_R5: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> run_len == (CW+1)'(CYCLES));

    // R5: a start raises busy on the next edge
    assert_start_raises_R5: assert property (@(posedge clk) disable iff (rst)
        start && !busy |=> busy);

endmodule

// File: rtl/pcb_byte_array.sv
module pcb_byte_array
    import pcb_pkg::*;
#(
    parameter int AW         = 8,
    parameter int PAGE_BYTES = 16,
    localparam int OW        = $clog2(PAGE_BYTES),
    localparam int PW        = AW - OW,
    localparam int DEPTH     = 1 << AW
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        wr_en,
    input  logic [PW-1:0]               wr_page,
    input  logic [PAGE_BYTES-1:0]       wr_mask,
    input  logic [PAGE_BYTES-1:0][7:0]  wr_lanes,
    input  logic [AW-1:0]               rd_addr,
    output byte_t                       rd_data
);

    byte_t         mem [DEPTH];
    logic [AW-1:0] lane_addr [PAGE_BYTES];

    for (genvar l = 0; l < PAGE_BYTES; l++) begin : g_lane
        assign lane_addr[l] = {wr_page, OW'(l)};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
            rd_data <= 8'hFF;
        end else begin
            rd_data <= mem[rd_addr];
            if (wr_en) begin
                for (int l = 0; l < PAGE_BYTES; l++)
                    if (wr_mask[l]) mem[lane_addr[l]] <= wr_lanes[l];
            end
        end
    end

    // R4: a commit always carries at least one byte
    assert_commit_nonempty_R4: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> |wr_mask);

endmodule

// File: rtl/page_commit_buf.sv
module page_commit_buf
    import pcb_pkg::*;
#(
    parameter int MEM_BYTES  = 256,
    parameter int PAGE_BYTES = 16,
    parameter int WR_CYCLES  = 40,
    localparam int AW        = $clog2(MEM_BYTES),
    localparam int OW        = $clog2(PAGE_BYTES),
    localparam int PW        = AW - OW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          addr_load,
    input  logic [AW-1:0] addr_val,
    input  logic          data_stb,
    input  logic [7:0]    data_in,
    input  logic          stop_stb,
    input  logic          wp_in,
    output logic          busy,
    output logic          ack_valid,
    output logic          ack_ok,
    input  logic [AW-1:0] rd_addr,
    output logic [7:0]    rd_data
);

    logic [PW-1:0]              page;
    logic [PAGE_BYTES-1:0]      mask;
    logic [PAGE_BYTES-1:0][7:0] lanes;
    logic                       commit_req;
    logic                       done;
    ack_t                       ack;

    pcb_page_buffer #(.AW(AW), .PAGE_BYTES(PAGE_BYTES)) u_buf (
        .clk(clk), .rst(rst), .hold(busy), .done(done),
        .addr_load(addr_load), .addr_val(addr_val),
        .data_stb(data_stb), .data_in(data_in),
        .stop_stb(stop_stb), .wp_in(wp_in),
        .page(page), .mask(mask), .lanes(lanes),
        .commit_req(commit_req), .ack(ack)
    );

    pcb_commit_timer #(.CYCLES(WR_CYCLES)) u_timer (
        .clk(clk), .rst(rst), .start(commit_req), .busy(busy), .done(done)
    );

    pcb_byte_array #(.AW(AW), .PAGE_BYTES(PAGE_BYTES)) u_array (
        .clk(clk), .rst(rst), .wr_en(done), .wr_page(page),
        .wr_mask(mask), .wr_lanes(lanes),
        .rd_addr(rd_addr), .rd_data(rd_data)
    );

    assign ack_valid = ack.valid;
    assign ack_ok    = ack.ok;

    // R8: a stop with nothing collected leaves busy low
    assert_empty_stop_idle_R8: assert property (@(posedge clk) disable iff (rst)
        stop_stb && !busy && mask == '0 |=> !busy);

    // R11: every strobe is answered on the next cycle
    assert_ack_follows_R11: assert property (@(posedge clk) disable iff (rst)
        data_stb |=> ack_valid);

endmodule

// File: tb/page_commit_buf_tb.sv
module page_commit_buf_tb;

    localparam int WR_CYCLES = 40;

    logic       clk = 1'b0;
    logic       rst;
    logic       addr_load, data_stb, stop_stb, wp_in;
    logic [7:0] addr_val, data_in, rd_addr, rd_data;
    logic       busy, ack_valid, ack_ok;

    int checks = 0;
    int fails  = 0;

    logic  exp_q[$];
    string tag_q[$];

    always #5 clk = ~clk;

    page_commit_buf #(.WR_CYCLES(WR_CYCLES)) u_dut (
        .clk(clk), .rst(rst), .addr_load(addr_load), .addr_val(addr_val),
        .data_stb(data_stb), .data_in(data_in), .stop_stb(stop_stb),
        .wp_in(wp_in), .busy(busy), .ack_valid(ack_valid), .ack_ok(ack_ok),
        .rd_addr(rd_addr), .rd_data(rd_data)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // monitor: compare each accept result against the scoreboard
    always @(negedge clk) begin
        if (!rst && ack_valid) begin
            if (exp_q.size() == 0) begin
                check("R11 unexpected ack", 1, 0);
            end else begin
                logic  e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(t, int'(ack_ok), int'(e));
            end
        end
    end

    task automatic load(input logic [7:0] a);
        @(negedge clk); addr_load = 1'b1; addr_val = a;
        @(negedge clk); addr_load = 1'b0;
    endtask

    task automatic send(input logic [7:0] d, input logic exp, input string tag);
        @(negedge clk); data_stb = 1'b1; data_in = d;
        exp_q.push_back(exp); tag_q.push_back(tag);
        @(negedge clk); data_stb = 1'b0;
    endtask

    task automatic stop();
        @(negedge clk); stop_stb = 1'b1;
        @(negedge clk); stop_stb = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [7:0] exp, input string tag);
        @(negedge clk); rd_addr = a;
        @(negedge clk); check(tag, int'(rd_data), int'(exp));
    endtask

    task automatic wait_commit(input string tag);
        int n = 0;
        while (busy && n < 1000) begin n++; @(negedge clk); end
        check(tag, n, WR_CYCLES);
    endtask

    task automatic wait_idle();
        int n = 0;
        while (busy && n < 1000) begin n++; @(negedge clk); end
    endtask

    task automatic no_busy(input string tag);
        for (int i = 0; i < 4; i++) begin
            check(tag, int'(busy), 0);
            @(negedge clk);
        end
    endtask

    initial begin
        #2_000_000;
        fails++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        rst = 1'b1; addr_load = 0; addr_val = 0; data_stb = 0; data_in = 0;
        stop_stb = 0; wp_in = 0; rd_addr = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset contents
        check("R1 busy after reset", int'(busy), 0);
        rd(8'h00, 8'hFF, "R1 byte 0x00");
        rd(8'h80, 8'hFF, "R1 byte 0x80");
        rd(8'hFF, 8'hFF, "R1 byte 0xFF");

        // R11: strobe with no open transaction
        send(8'h42, 1'b0, "R11 strobe before address");
        no_busy("R11 no commit");

        // R4/R5/R10: single byte write
        load(8'h23);
        send(8'h5A, 1'b1, "R2 single byte ack");
        stop();
        wait_commit("R5 busy length");
        rd(8'h23, 8'h5A, "R4 written byte");
        rd(8'h22, 8'hFF, "R4 neighbour below");
        rd(8'h24, 8'hFF, "R4 neighbour above");

        // R5: traffic during busy
        load(8'h24);
        send(8'h66, 1'b1, "R5 setup ack");
        stop();
        send(8'h99, 1'b0, "R5 strobe during busy");
        rd(8'h24, 8'hFF, "R5 old value during busy");
        check("R5 still busy", int'(busy), 1);
        wait_idle();
        rd(8'h24, 8'h66, "R5 value after busy");
        rd(8'h25, 8'hFF, "R5 refused byte absent");
        send(8'h77, 1'b0, "R11 strobe after stop");

        // R2: offset wraps inside page
        load(8'h3E);
        for (int i = 0; i < 4; i++) send(8'h11 + 8'(i), 1'b1, "R2 page ack");
        stop();
        wait_commit("R5 busy length page");
        rd(8'h3E, 8'h11, "R2 offset E");
        rd(8'h3F, 8'h12, "R2 offset F");
        rd(8'h30, 8'h13, "R2 wrapped offset 0");
        rd(8'h31, 8'h14, "R2 wrapped offset 1");
        rd(8'h40, 8'hFF, "R2 next page untouched");
        rd(8'h32, 8'hFF, "R4 page byte untouched");

        // R3: more than 16 bytes overwrite
        load(8'h50);
        for (int i = 0; i < 18; i++) send(8'hA0 + 8'(i), 1'b1, "R3 ack");
        stop();
        wait_commit("R3 busy length");
        rd(8'h50, 8'hB0, "R3 overwritten offset 0");
        rd(8'h51, 8'hB1, "R3 overwritten offset 1");
        rd(8'h52, 8'hA2, "R3 kept offset 2");
        rd(8'h5F, 8'hAF, "R3 kept offset F");

        // R6: protected upper half
        wp_in = 1'b1;
        load(8'h90);
        send(8'hC1, 1'b0, "R6 first byte refused");
        send(8'hC2, 1'b0, "R6 second byte refused");
        wp_in = 1'b0;
        send(8'hC3, 1'b0, "R6 still refused after wp low");
        stop();
        no_busy("R6 no commit");
        rd(8'h90, 8'hFF, "R6 byte unchanged");

        // R7: wp on lower half, wp late change
        wp_in = 1'b1;
        load(8'h10);
        send(8'h77, 1'b1, "R7 lower half ack");
        stop();
        wait_commit("R7 busy length");
        rd(8'h10, 8'h77, "R7 lower half written");
        wp_in = 1'b0;
        load(8'hA0);
        send(8'h88, 1'b1, "R7 upper wp low ack");
        wp_in = 1'b1;
        send(8'h89, 1'b1, "R7 late wp ignored");
        stop();
        wp_in = 1'b0;
        wait_commit("R7 busy length upper");
        rd(8'hA0, 8'h88, "R7 upper byte 0");
        rd(8'hA1, 8'h89, "R7 upper byte 1");

        // R8: stop before data
        load(8'h60);
        stop();
        no_busy("R8 empty stop");

        // R9: reload clears mask
        load(8'h70);
        send(8'h01, 1'b1, "R9 first ack");
        load(8'h75);
        send(8'h02, 1'b1, "R9 second ack");
        stop();
        wait_commit("R9 busy length");
        rd(8'h70, 8'hFF, "R9 dropped byte");
        rd(8'h75, 8'h02, "R9 kept byte");

        repeat (3) @(negedge clk);
        check("R11 scoreboard drained", exp_q.size(), 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule